// File: doc/BRIEF.md
# Nested Vectored Priority Resolver

This block decides which of sixteen programmable vector slots holds the most urgent pending interrupt source. It hands that slot's handler address to software and keeps a stack of priority levels, so that a higher-priority request can preempt a handler that is already running. Each slot is bound to one of 32 request lines by a control byte. Lower slot numbers win. A seventeenth, unvectored level catches requests that no enabled slot serves, and an idle level sits below all of them.

Software reads the current-vector register when a handler starts. That read finds the winning level, raises the current priority to it, saves the level it left, and returns the handler address. Software writes the same register when the handler ends, and that write unwinds to the saved level. The normal interrupt output is asserted only for already-masked normal requests that outrank the current level. Source enabling and fast routing happen upstream, so the block takes both the raw request vector and the masked normal vector as inputs.

The nesting controller is a two-state machine. NEST_IDLE means the current level is idle. NEST_ACTIVE means at least one level is pushed. Its transitions are:
- push-from-idle: NEST_IDLE to NEST_ACTIVE.
- push-deeper: NEST_ACTIVE to NEST_ACTIVE, at a lower level number.
- pop-to-active: NEST_ACTIVE to NEST_ACTIVE, when the restored level is not idle.
- pop-to-idle: NEST_ACTIVE to NEST_IDLE.
- hold: the state is kept on any other cycle.

Top module: `vec_prio_resolver`

## Requirements
- R1: After reset, the current level is idle (17), and every slot address, every slot control byte, the default address and rdata are zero.
- R2: A slot control byte enables its slot with bit 5, and bits 4:0 name the source the slot serves. The mask of level i is the OR of the source bits of all enabled slots numbered below i. Level 16 covers every enabled slot. The idle level's mask is all ones. A disabled slot adds nothing to any mask.
- R3: irq_out is high exactly when norm_req AND the mask of the current level is nonzero. It follows the current level in the same cycle the level register changes.
- R4: A read at byte 0x30 (word 12) finds the lowest level i below the current level for which raw_req AND mask(i+1) is nonzero. If one is found, it saves the current level in entry i and makes i the current level. One cycle later, rdata holds the address of the resulting level: slot address for levels 0 to 15, default address for levels 16 and 17.
- R5: A read at word 12 while idle with no raw request leaves the level idle and returns the default address.
- R6: A write at word 12 ignores its data. If the current level is below idle, the write restores the level saved in that level's entry. While idle, the write has no effect.
- R7: Slot k's address sits at byte 0x100+4k. Slot k's control byte sits at 0x200+4k, keeps 8 bits and reads back zero-extended. The default address sits at byte 0x34. Read data appears one cycle after rd_en. Other addresses read as zero and ignore writes.
- R8: Nested pushes save one level per entry, and successive writes at word 12 unwind them in reverse order.
- R9: When rd_en and wr_en are asserted together, only the write is performed. The read has no side effect, and rdata keeps its previous value.
- R10: The search at word 12 uses raw_req, not norm_req. A raw-only request still pushes the level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_req | input | 32 | Raw request lines, used by the vector search |
| norm_req | input | 32 | Requests already enabled and routed to the normal output |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Normal interrupt request output |

## Verification
A push and a pop can be requested in the same cycle, because one bus carries both strobes to the current-vector register. The bench nests to a slot level and then asserts rd_en and wr_en together at word 12. It judges the outcome by two things: rdata must keep the previous handler address, and irq_out must show that the level unwound to idle. A second coincidence is a vector read in the same cycle that a new raw request appears. This is provoked by pushing while a higher slot's raw line is already raised, and the bench checks that the deeper slot's address is returned.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
    localparam int VEC_WORD        = 12;
    localparam int DEF_WORD        = 13;
    localparam int SLOT_ADDR_BASE  = 64;   // byte 0x100
    localparam int SLOT_CTRL_BASE  = 128;  // byte 0x200
    localparam int CTRL_W          = 8;
    localparam int CTRL_EN_BIT     = 5;

    typedef enum logic [1:0] {
        NEST_IDLE   = 2'd0,
        NEST_ACTIVE = 2'd1
    } nest_state_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PUSH   = 3'd1,
        OP_POP    = 3'd2,
        OP_CFG_WR = 3'd3,
        OP_CFG_RD = 3'd4
    } bus_op_e;
endpackage

// File: rtl/vpr_cfg_regs.sv
module vpr_cfg_regs
    import vpr_pkg::*;
#(
    parameter int NUM_SLOT = 16,
    parameter int DATA_W   = 32,
    parameter int WORD_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] slot_addr [NUM_SLOT],
    output logic [CTRL_W-1:0] slot_ctrl [NUM_SLOT],
    output logic [DATA_W-1:0] def_addr,
    output logic [DATA_W-1:0] cfg_rdata
);
    // Storage for slot handler addresses, slot control bytes and default address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_SLOT; k++) begin
                slot_addr[k] <= '0;
                slot_ctrl[k] <= '0;
            end
            def_addr <= '0;
        end else if (cfg_wr) begin
            if (word == WORD_W'(DEF_WORD)) def_addr <= wdata;
            for (int k = 0; k < NUM_SLOT; k++) begin
                if (word == WORD_W'(SLOT_ADDR_BASE + k)) slot_addr[k] <= wdata;
                if (word == WORD_W'(SLOT_CTRL_BASE + k)) slot_ctrl[k] <= wdata[CTRL_W-1:0];
            end
        end
    end

    // Read mux; unmapped words return zero
    always_comb begin
        cfg_rdata = '0;
        if (word == WORD_W'(DEF_WORD)) cfg_rdata = def_addr;
        for (int k = 0; k < NUM_SLOT; k++) begin
            if (word == WORD_W'(SLOT_ADDR_BASE + k)) cfg_rdata = slot_addr[k];
            if (word == WORD_W'(SLOT_CTRL_BASE + k)) cfg_rdata = DATA_W'(slot_ctrl[k]);
        end
    end
endmodule

// File: rtl/vpr_mask_chain.sv
module vpr_mask_chain
    import vpr_pkg::*;
#(
    parameter int NUM_SLOT = 16,
    parameter int NUM_SRC  = 32
) (
    input  logic [CTRL_W-1:0]  slot_ctrl [NUM_SLOT],
    output logic [NUM_SRC-1:0] lvl_mask  [NUM_SLOT+2]
);
    localparam int SRC_W = $clog2(NUM_SRC);

    // Cumulative masks: entry i collects sources of enabled slots below i
    always_comb begin
        logic [NUM_SRC-1:0] acc;
        acc = '0;
        for (int k = 0; k < NUM_SLOT; k++) begin
            lvl_mask[k] = acc;
            if (slot_ctrl[k][CTRL_EN_BIT]) acc[slot_ctrl[k][SRC_W-1:0]] = 1'b1;
        end
        lvl_mask[NUM_SLOT]   = acc;
        lvl_mask[NUM_SLOT+1] = '1;
    end

    logic unused_ctrl_hi;
    always_comb begin
        unused_ctrl_hi = 1'b0;
        for (int k = 0; k < NUM_SLOT; k++) begin
            unused_ctrl_hi = unused_ctrl_hi ^ (^slot_ctrl[k][CTRL_W-1:CTRL_EN_BIT+1]);
        end
    end
endmodule

// File: rtl/vpr_search.sv
module vpr_search #(
    parameter int NUM_SLOT = 16,
    parameter int NUM_SRC  = 32,
    parameter int LVL_W    = 5
) (
    input  logic [NUM_SRC-1:0] raw_req,
    input  logic [NUM_SRC-1:0] lvl_mask [NUM_SLOT+2],
    input  logic [LVL_W-1:0]   cur_lvl,
    output logic               found,
    output logic [LVL_W-1:0]   win_lvl
);
    localparam int LVL_IDLE = NUM_SLOT + 1;

    // Lowest level i below the current one whose upper mask hits a raw request
    always_comb begin
        found   = 1'b0;
        win_lvl = cur_lvl;
        for (int i = LVL_IDLE - 1; i >= 0; i--) begin
            if ((LVL_W'(i) < cur_lvl) && (|(raw_req & lvl_mask[i+1]))) begin
                found   = 1'b1;
                win_lvl = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/vpr_nest_ctrl.sv
module vpr_nest_ctrl
    import vpr_pkg::*;
#(
    parameter int NUM_SLOT = 16,
    parameter int LVL_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             found,
    input  logic [LVL_W-1:0] win_lvl,
    output logic [LVL_W-1:0] cur_lvl,
    output nest_state_e      state
);
    localparam int LVL_IDLE = NUM_SLOT + 1;

    logic [LVL_W-1:0] saved_lvl [LVL_IDLE+1];
    nest_state_e      state_nxt;
    logic             at_idle;
    logic             do_push;
    logic             do_pop;

    assign at_idle = (cur_lvl == LVL_W'(LVL_IDLE));
    assign do_push = push_req && found;
    assign do_pop  = pop_req && !at_idle;

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            NEST_IDLE: begin
                if (do_push) state_nxt = NEST_ACTIVE;              // push-from-idle
            end
            NEST_ACTIVE: begin
                if (do_pop && saved_lvl[cur_lvl] == LVL_W'(LVL_IDLE))
                    state_nxt = NEST_IDLE;                          // pop-to-idle
            end
            default: state_nxt = NEST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= NEST_IDLE;
        else        state <= state_nxt;
    end

    // Level register and saved-level table
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_lvl <= LVL_W'(LVL_IDLE);
            for (int i = 0; i <= LVL_IDLE; i++) saved_lvl[i] <= LVL_W'(LVL_IDLE);
        end else if (do_push) begin
            saved_lvl[win_lvl] <= cur_lvl;
            cur_lvl            <= win_lvl;
        end else if (do_pop) begin
            cur_lvl <= saved_lvl[cur_lvl];
        end
    end
endmodule

// File: rtl/vec_prio_resolver.sv
module vec_prio_resolver
    import vpr_pkg::*;
#(
    parameter int NUM_SLOT = 16,
    parameter int NUM_SRC  = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] raw_req,
    input  logic [NUM_SRC-1:0] norm_req,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_out
);
    localparam int LVL_W   = $clog2(NUM_SLOT + 2);
    localparam int WORD_W  = ADDR_W - 2;
    localparam int SLOT_IW = $clog2(NUM_SLOT);

    logic [WORD_W-1:0]  word;
    logic               unused_addr_lsb;
    bus_op_e            op;
    logic [DATA_W-1:0]  slot_addr [NUM_SLOT];
    logic [CTRL_W-1:0]  slot_ctrl [NUM_SLOT];
    logic [DATA_W-1:0]  def_addr;
    logic [DATA_W-1:0]  cfg_rdata;
    logic [NUM_SRC-1:0] lvl_mask [NUM_SLOT+2];
    logic               found;
    logic [LVL_W-1:0]   win_lvl;
    logic [LVL_W-1:0]   cur_lvl;
    nest_state_e        nest_state;
    logic [DATA_W-1:0]  vec_addr;

    assign word            = addr[ADDR_W-1:2];
    assign unused_addr_lsb = ^addr[1:0];

    // Bus operation decode; a write outranks a read in the same cycle
    always_comb begin
        op = OP_NONE;
        if (wr_en)      op = (word == WORD_W'(VEC_WORD)) ? OP_POP  : OP_CFG_WR;
        else if (rd_en) op = (word == WORD_W'(VEC_WORD)) ? OP_PUSH : OP_CFG_RD;
    end

    vpr_cfg_regs #(
        .NUM_SLOT (NUM_SLOT),
        .DATA_W   (DATA_W),
        .WORD_W   (WORD_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (op == OP_CFG_WR),
        .word      (word),
        .wdata     (wdata),
        .slot_addr (slot_addr),
        .slot_ctrl (slot_ctrl),
        .def_addr  (def_addr),
        .cfg_rdata (cfg_rdata)
    );

    vpr_mask_chain #(
        .NUM_SLOT (NUM_SLOT),
        .NUM_SRC  (NUM_SRC)
    ) u_mask (
        .slot_ctrl (slot_ctrl),
        .lvl_mask  (lvl_mask)
    );

    vpr_search #(
        .NUM_SLOT (NUM_SLOT),
        .NUM_SRC  (NUM_SRC),
        .LVL_W    (LVL_W)
    ) u_search (
        .raw_req  (raw_req),
        .lvl_mask (lvl_mask),
        .cur_lvl  (cur_lvl),
        .found    (found),
        .win_lvl  (win_lvl)
    );

    vpr_nest_ctrl #(
        .NUM_SLOT (NUM_SLOT),
        .LVL_W    (LVL_W)
    ) u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (op == OP_PUSH),
        .pop_req  (op == OP_POP),
        .found    (found),
        .win_lvl  (win_lvl),
        .cur_lvl  (cur_lvl),
        .state    (nest_state)
    );

    // Handler address of the level the read lands on
    always_comb begin
        if (win_lvl < LVL_W'(NUM_SLOT)) vec_addr = slot_addr[win_lvl[SLOT_IW-1:0]];
        else                            vec_addr = def_addr;
    end

    // Registered read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            unique case (op)
                OP_PUSH:   rdata <= vec_addr;
                OP_CFG_RD: rdata <= cfg_rdata;
                default:   rdata <= rdata;
            endcase
        end
    end

    // Normal interrupt output
    assign irq_out = |(norm_req & lvl_mask[cur_lvl]);
endmodule

// File: rtl/vpr_checker.sv
module vpr_checker
    import vpr_pkg::*;
#(
    parameter int NUM_SLOT = 16,
    parameter int NUM_SRC  = 32,
    parameter int ADDR_W   = 12,
    parameter int LVL_W    = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [NUM_SRC-1:0] norm_req,
    input logic               irq_out,
    input logic [LVL_W-1:0]   cur_lvl,
    input nest_state_e        nest_state
);
    localparam int LVL_IDLE = NUM_SLOT + 1;

    logic vec_sel, vec_rd, vec_wr, idle_lvl;
    assign vec_sel  = (addr[ADDR_W-1:2] == (ADDR_W-2)'(VEC_WORD));
    assign vec_rd   = rd_en && !wr_en && vec_sel;
    assign vec_wr   = wr_en && vec_sel;
    assign idle_lvl = (cur_lvl == LVL_W'(LVL_IDLE));

    AST_STATE_TRACKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (nest_state == NEST_IDLE) == idle_lvl); // R8
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cur_lvl <= LVL_W'(LVL_IDLE)); // R4
    AST_PUSH_NEVER_LOWERS: assert property (@(posedge clk) disable iff (!rst_n) vec_rd |=> cur_lvl <= $past(cur_lvl)); // R4
    AST_POP_UNWINDS: assert property (@(posedge clk) disable iff (!rst_n) (vec_wr && !idle_lvl) |=> cur_lvl > $past(cur_lvl)); // R6
    AST_POP_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (vec_wr && idle_lvl) |=> idle_lvl); // R6
    AST_QUIET_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (norm_req == '0) |-> !irq_out); // R3
    AST_OTHER_ACCESS_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (!vec_rd && !vec_wr) |=> $stable(cur_lvl)); // R7
    AST_BOTH_STROBES_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && wr_en && vec_sel) |=> cur_lvl >= $past(cur_lvl)); // R9
endmodule

bind vec_prio_resolver vpr_checker #(
    .NUM_SLOT (NUM_SLOT),
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W),
    .LVL_W    (LVL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .addr       (addr),
    .norm_req   (norm_req),
    .irq_out    (irq_out),
    .cur_lvl    (cur_lvl),
    .nest_state (nest_state)
);

// File: tb/sim_vec_prio_resolver.sv
module sim_vec_prio_resolver;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] raw_req, norm_req, wdata;
    logic        rd_en, wr_en;
    logic [11:0] addr;
    logic [31:0] rdata;
    logic        irq_out;

    always #10 clk = ~clk;   // 50 MHz

    vec_prio_resolver u0 (
        .clk(clk), .rst_n(rst_n), .raw_req(raw_req), .norm_req(norm_req),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_out(irq_out)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of the requirements
    logic [31:0] m_addr [16];
    logic [7:0]  m_ctrl [16];
    logic [31:0] m_def;
    int          m_lvl;
    int          m_saved [18];
    logic [31:0] m_rdata;

    function automatic logic [31:0] mask_of(int j);
        logic [31:0] m;
        m = '0;
        if (j >= 17) return '1;
        for (int k = 0; k < j; k++) if (m_ctrl[k][5]) m[m_ctrl[k][4:0]] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] addr_of(int l);
        return (l < 16) ? m_addr[l] : m_def;
    endfunction

    function automatic logic [31:0] cfg_of(int w);
        if (w == 13) return m_def;
        if (w >= 64 && w < 80) return m_addr[w-64];
        if (w >= 128 && w < 144) return {24'b0, m_ctrl[w-128]};
        return 32'b0;
    endfunction

    function automatic int src_of(int k);
        return (7*k + 3) % 32;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_irq(string req);
        chk(req, {31'b0, irq_out}, {31'b0, |(norm_req & mask_of(m_lvl))});
    endtask

    task automatic set_req(logic [31:0] r, logic [31:0] n);
        @(negedge clk);
        raw_req = r; norm_req = n;
        #2;
    endtask

    task automatic bus_rd(logic [11:0] a);
        int w, i;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        w = int'(a >> 2);
        if (w == 12) begin
            i = 0;
            while (i < m_lvl && (raw_req & mask_of(i+1)) == 32'b0) i++;
            if (i < m_lvl) begin m_saved[i] = m_lvl; m_lvl = i; end
            m_rdata = addr_of(m_lvl);
        end else begin
            m_rdata = cfg_of(w);
        end
        @(negedge clk);
        rd_en = 1'b0;
        #2;
    endtask

    task automatic model_wr(logic [11:0] a, logic [31:0] d);
        int w;
        w = int'(a >> 2);
        if (w == 12) begin
            if (m_lvl < 17) m_lvl = m_saved[m_lvl];
        end else if (w == 13) m_def = d;
        else if (w >= 64 && w < 80) m_addr[w-64] = d;
        else if (w >= 128 && w < 144) m_ctrl[w-128] = d[7:0];
    endtask

    task automatic bus_wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        model_wr(a, d);
        @(negedge clk);
        wr_en = 1'b0;
        #2;
    endtask

    task automatic bus_both(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b1;
        model_wr(a, d);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        #2;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; raw_req = '0; norm_req = '0; wdata = '0;
        rd_en = 1'b0; wr_en = 1'b0; addr = '0;
        for (int k = 0; k < 16; k++) begin m_addr[k] = '0; m_ctrl[k] = '0; end
        for (int k = 0; k < 18; k++) m_saved[k] = 17;
        m_def = '0; m_lvl = 17; m_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;

        // R1: reset state
        chk("R1 rdata after reset", rdata, 32'h0);
        chk_irq("R1 quiet irq");
        set_req('0, 32'hFFFF_FFFF);
        chk("R1 idle level mask all ones", {31'b0, irq_out}, 32'h1);
        bus_rd(12'h100); chk("R1 slot address zero", rdata, 32'h0);
        bus_rd(12'h23C); chk("R1 control byte zero", rdata, 32'h0);
        bus_rd(12'h034); chk("R1 default zero", rdata, 32'h0);

        // R7: program map and read back
        for (int k = 0; k < 16; k++) begin
            bus_wr(12'(12'h100 + 4*k), 32'hC0DE_0000 | 32'(k << 4));
            bus_wr(12'(12'h200 + 4*k), ((k == 5 || k == 11) ? 32'h0 : 32'h20) | 32'(src_of(k)));
        end
        bus_wr(12'h034, 32'hDEF0_0001);
        for (int k = 0; k < 16; k++) begin
            bus_rd(12'(12'h100 + 4*k)); chk("R7 slot address readback", rdata, m_rdata);
            bus_rd(12'(12'h200 + 4*k)); chk("R7 control readback", rdata, m_rdata);
        end
        bus_rd(12'h034); chk("R7 default readback", rdata, 32'hDEF0_0001);
        bus_wr(12'h044, 32'hFFFF_FFFF);
        bus_rd(12'h044); chk("R7 unmapped reads zero", rdata, 32'h0);
        bus_rd(12'h034); chk("R7 unmapped write ignored", rdata, 32'hDEF0_0001);

        // R5: idle read with nothing pending
        set_req('0, '0);
        bus_rd(12'h030); chk("R5 empty read gives default", rdata, 32'hDEF0_0001);
        set_req('0, 32'h1);
        chk_irq("R5 still idle");

        // R6: pop while idle has no effect
        bus_wr(12'h030, 32'h1234_5678);
        chk_irq("R6 pop at idle ignored");

        // R3 R4 R6 sweep over every single source
        for (int s = 0; s < 32; s++) begin
            set_req(32'h1 << s, 32'h1 << s);
            chk_irq("R3 idle single source");
            bus_rd(12'h030); chk("R4 vector read per source", rdata, m_rdata);
            chk_irq("R3 after push");
            bus_wr(12'h030, 32'hFFFF_FFFF);
            chk_irq("R6 after pop");
        end

        // R2: mask sweep while parked at slot 8
        set_req(32'h1 << src_of(8), '0);
        bus_rd(12'h030); chk("R4 push to slot 8", rdata, 32'hC0DE_0080);
        for (int t = 0; t < 32; t++) begin
            set_req(32'h1 << src_of(8), 32'h1 << t);
            chk_irq("R2 level mask sweep");
        end
        bus_wr(12'h030, '0);

        // R8: nesting
        set_req(32'h1 << src_of(9), '0);
        bus_rd(12'h030); chk("R8 first push slot 9", rdata, 32'hC0DE_0090);
        set_req((32'h1 << src_of(9)) | (32'h1 << src_of(2)), 32'h1 << src_of(2));
        chk_irq("R8 higher request preempts");
        bus_rd(12'h030); chk("R8 nested push slot 2", rdata, 32'hC0DE_0020);
        bus_rd(12'h030); chk("R8 no deeper push", rdata, 32'hC0DE_0020);
        set_req(32'h1 << src_of(9), 32'h1 << src_of(4));
        chk_irq("R8 at level 2 slot 4 masked");
        bus_wr(12'h030, '0);
        chk_irq("R8 unwound to slot 9");
        bus_wr(12'h030, '0);
        set_req('0, 32'h1 << src_of(9));
        chk_irq("R8 unwound to idle");

        // R10: raw-only request pushes
        set_req(32'h1 << src_of(3), '0);
        bus_rd(12'h030); chk("R10 raw only push", rdata, 32'hC0DE_0030);
        set_req(32'h1 << src_of(3), 32'h1 << src_of(1));
        chk_irq("R10 level 3 reached");
        bus_wr(12'h030, '0);

        // R9: both strobes at once while nested
        set_req(32'h1 << src_of(6), '0);
        bus_rd(12'h030); chk("R9 setup push", rdata, 32'hC0DE_0060);
        bus_both(12'h030, 32'h55);
        chk("R9 rdata held", rdata, 32'hC0DE_0060);
        set_req('0, 32'h1 << src_of(6));
        chk_irq("R9 pop performed");

        // R2: disabled slot's source falls to default level
        set_req(32'h1 << src_of(5), '0);
        bus_rd(12'h030); chk("R2 disabled slot uses default", rdata, 32'hDEF0_0001);
        bus_wr(12'h030, '0);

        // R7: control byte keeps 8 bits
        bus_wr(12'h23C, 32'h0000_01E7);
        bus_rd(12'h23C); chk("R7 control byte width", rdata, 32'h0000_00E7);
        set_req(32'h1 << 7, 32'h1 << 7);
        bus_rd(12'h030); chk("R2 rewritten slot 15", rdata, m_rdata);
        chk_irq("R3 after rewritten push");
        bus_wr(12'h030, '0);

        summary();
        $finish;
    end
endmodule